// File: doc/BRIEF.md
# Pipelined Carry-Save Array Multiplier

The block multiplies two unsigned W-bit operands and returns the full 2W-bit product. The product is built row by row in carry-save form, so no carry travels sideways within a row. Row zero only forms the AND terms of the multiplicand with the lowest multiplier bit. Each later row adds one shifted partial-product row to the running sum and carry vectors with full adders. After row i, bit i of the product is final.

Carry propagation for the upper half is not done in one ripple row. It is spread over W-1 further pipeline stages, and each of these stages resolves one bit position and hands its carry to the next stage. Every stage therefore costs about one full-adder delay. Bits that are already final ride along in the stage registers, so all 2W bits leave together. Latency is a fixed 2W-1 cycles. One new operation can be accepted every cycle.

Top module: `csaPipeMul`

## Requirements
- R1: While reset is asserted and after it is released, `outValid` is 0 and `product` is 0, until the first result emerges.
- R2: For each accepted operation, `product` equals `mcand` × `mplier` as unsigned integers, with all 2W bits.
- R3: An operation accepted at a rising edge where `inValid` is 1 shows `outValid` = 1 with its product right after the rising edge 2W-2 cycles later. That is 2W-1 cycles counted from the accepting edge, inclusive.
- R4: Operations offered on consecutive cycles are all accepted. Their results appear on consecutive cycles in the same order.
- R5: A cycle with `inValid` = 0 produces no output pulse. The gaps in the input stream reappear unchanged in `outValid`, and operand values presented on such cycles have no effect on any result.
- R6: While `outValid` is 0, `product` keeps the value of the most recent result.
- R7: The boundary operands give exact products: all-ones × all-ones gives 2^(2W) − 2^(W+1) + 1, and a zero operand gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operands present this cycle |
| mcand | input | W | Unsigned multiplicand |
| mplier | input | W | Unsigned multiplier |
| outValid | output | 1 | Product present this cycle |
| product | output | 2W | Unsigned product |

## Verification
In the same cycle, the pipeline can accept a new operation at its head and emit an older result at its tail. It can also finish a ripple stage for one operand pair while the CSA rows hold other pairs. The bench provokes both with an exhaustive back-to-back sweep over all operand pairs at W = 4, which keeps every stage full, and a second sweep with irregular idle gaps that carry garbage operands. Each result is judged against the arithmetic product, against the cycle in which it was offered plus 2W-1, and against its order in a queue. Between results, the held product is compared with the last one seen.

// File: rtl/csaPipeMulPkg.sv
package csaPipeMulPkg;

  // Strobes from control to datapath for the ends of the pipe.
  typedef struct packed {
    logic take;   // head stage loads new operands
    logic emit;   // tail stage loads a finished product
  } ctrlStrobe_t;

endpackage

// File: rtl/csaPipeMulCtrl.sv
module csaPipeMulCtrl
  import csaPipeMulPkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output ctrlStrobe_t       strobe,
  output logic [2*W-4:0]    midEn,
  output logic              outValid
);

  localparam int STAGES = 2 * W - 1;
  localparam int CW     = $clog2(STAGES + 1);

  logic [STAGES-1:0] validPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validPipe <= '0;
    else       validPipe <= {validPipe[STAGES-2:0], inValid};
  end

  assign strobe.take = inValid;
  assign strobe.emit = validPipe[STAGES-2];
  assign midEn       = validPipe[STAGES-3:0];
  assign outValid    = validPipe[STAGES-1];

  // Cycles since reset, saturating; used only to bound the first output.
  logic [CW-1:0] sinceReset;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         sinceReset <= '0;
    else if (sinceReset != CW'(STAGES)) sinceReset <= sinceReset + 1'b1;
  end

  // R3: no result can leave before the pipe has been filled once.
  assert_no_early_out_R3: assert property (@(posedge clk) disable iff (!rstN)
    (sinceReset < CW'(STAGES)) |-> !outValid);

endmodule

// File: rtl/csaPipeMulPath.sv
module csaPipeMulPath
  import csaPipeMulPkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [2*W-4:0]    midEn,
  input  logic [W-1:0]      mcand,
  input  logic [W-1:0]      mplier,
  output logic [2*W-1:0]    product
);

  localparam int PW     = 2 * W;
  localparam int STAGES = 2 * W - 1;

  typedef struct packed {
    logic [PW-1:0] sum;
    logic [PW-1:0] cry;
    logic [W-1:0]  mcand;
    logic [W-1:0]  mplier;
    logic          rc;      // ripple carry between final stages
  } stage_t;

  stage_t st [STAGES];
  stage_t nx [STAGES];
  logic [STAGES-1:0] ld;

  assign ld = {strobe.emit, midEn, strobe.take};

  // Row zero: AND terms only.
  always_comb begin
    nx[0]        = '0;
    nx[0].sum    = PW'(mcand & {W{mplier[0]}});
    nx[0].mcand  = mcand;
    nx[0].mplier = mplier;
  end

  genvar k;
  generate
    for (k = 1; k < STAGES; k++) begin : g_stage
      if (k < W) begin : g_csa
        // Carry-save row: add one shifted partial-product row.
        logic [PW-1:0] pp;
        always_comb begin
          pp        = {{W{1'b0}}, st[k-1].mcand & {W{st[k-1].mplier[k]}}} << k;
          nx[k]     = st[k-1];
          nx[k].sum = st[k-1].sum ^ st[k-1].cry ^ pp;
          nx[k].cry = ((st[k-1].sum & st[k-1].cry) |
                       (st[k-1].sum & pp) |
                       (st[k-1].cry & pp)) << 1;
        end
      end else begin : g_rip
        // One resolved bit per stage; carry moves one position.
        logic s0, c0, r0, rOut;
        always_comb begin
          s0        = st[k-1].sum[k];
          c0        = st[k-1].cry[k];
          r0        = st[k-1].rc;
          rOut      = (s0 & c0) | (s0 & r0) | (c0 & r0);
          nx[k]     = st[k-1];
          nx[k].sum[k] = s0 ^ c0 ^ r0;
          nx[k].cry[k] = 1'b0;
          nx[k].rc     = rOut;
          if (k == STAGES - 1) begin
            nx[k].sum[PW-1] = st[k-1].sum[PW-1] ^ st[k-1].cry[PW-1] ^ rOut;
            nx[k].cry[PW-1] = 1'b0;
            nx[k].rc        = 1'b0;
          end
        end
      end
    end

    for (k = 0; k < STAGES; k++) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)      st[k] <= '0;
        else if (ld[k]) st[k] <= nx[k];
      end

      // R2: below the resolved position no carry remains in any stage.
      assert_low_carry_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
        st[k].cry[k:0] == '0);
    end
  endgenerate

  assign product = st[STAGES-1].sum;

  // R2: the tail stage holds a fully resolved product, no carry left over.
  assert_tail_resolved_R2: assert property (@(posedge clk) disable iff (!rstN)
    (st[STAGES-1].cry == '0) && !st[STAGES-1].rc);

endmodule

// File: rtl/csaPipeMul.sv
module csaPipeMul
  import csaPipeMulPkg::*;
#(
  parameter int W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [W-1:0]    mcand,
  input  logic [W-1:0]    mplier,
  output logic            outValid,
  output logic [2*W-1:0]  product
);

  ctrlStrobe_t     strobe;
  logic [2*W-4:0]  midEn;

  csaPipeMulCtrl #(.W(W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .midEn    (midEn),
    .outValid (outValid)
  );

  csaPipeMulPath #(.W(W)) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .midEn   (midEn),
    .mcand   (mcand),
    .mplier  (mplier),
    .product (product)
  );

  // R6: between results the product output does not move.
  assert_hold_between_R6: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(product));

endmodule

// File: tb/test_csaPipeMul.sv
`timescale 1ns/1ps
module test_csaPipeMul;

  localparam int W   = 4;
  localparam int PW  = 2 * W;
  localparam int LAT = 2 * W - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [W-1:0]  mcand = '0;
  logic [W-1:0]  mplier = '0;
  logic          outValid;
  logic [PW-1:0] product;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [PW-1:0] lastProd = '0;
  logic [PW-1:0] expQ [$];
  int            cycQ [$];
  logic          monOn = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  csaPipeMul #(.W(W)) i_csaPipeMul (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .mcand(mcand), .mplier(mplier),
    .outValid(outValid), .product(product)
  );

  task automatic check(input bit ok, input string req, input logic [PW-1:0] act,
                       input logic [PW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic send(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    inValid = 1'b1; mcand = a; mplier = b;
    expQ.push_back(PW'(a) * PW'(b));
    cycQ.push_back(cyc + LAT);
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
    mcand = W'($urandom); mplier = W'($urandom);
  endtask

  // Monitor: judges every output cycle at the falling edge.
  always @(negedge clk) begin
    if (monOn) begin
      if (outValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R5 spurious outValid", product, '0);
        end else begin
          logic [PW-1:0] e;
          int ec;
          e = expQ.pop_front();
          ec = cycQ.pop_front();
          check(product == e, "R2/R4 product", product, e);
          check(cyc == ec, "R3 latency cycle", PW'(cyc), PW'(ec));
          lastProd = product;
        end
      end else begin
        check(product == lastProd, "R6 hold", product, lastProd);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1 outValid in reset", PW'(outValid), '0);
    check(product == '0, "R1 product in reset", product, '0);
    @(negedge clk);
    rstN = 1'b1;
    monOn = 1'b1;
    repeat (4) idle();

    // R7 boundary operands.
    send('1, '1);
    send('1, '0);
    send('0, '1);
    send(W'(1), '1);
    repeat (LAT + 2) idle();

    // R4 exhaustive back-to-back sweep.
    for (int a = 0; a < (1 << W); a++)
      for (int b = 0; b < (1 << W); b++)
        send(W'(a), W'(b));
    repeat (LAT + 2) idle();

    // R5 sweep with irregular gaps carrying garbage operands.
    for (int a = 0; a < (1 << W); a++)
      for (int b = 0; b < (1 << W); b++) begin
        send(W'(b), W'(a));
        if (((a * 7 + b) % 5) == 0) idle();
        if (((a + b) % 11) == 0) begin idle(); idle(); end
      end
    repeat (LAT + 3) idle();

    check(expQ.size() == 0, "R4/R5 all results emitted", PW'(expQ.size()), '0);
    check(product == PW'((1 << W) - 1) * PW'((1 << W) - 1) ||
          product == lastProd, "R6 final hold", product, lastProd);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual %0d expected %0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule